// File: doc/BRIEF.md
# Serial Table-Read Responder

This block is the target side of a two-wire programming link. A host toggles a serial clock and drives a shared data line. Every frame is 20 serial clocks long: a 4-bit command comes first, then a 16-bit payload. The responder samples the data line on falling serial-clock edges. It oversamples both link lines with its own system clock through a short synchronizer.

The responder holds a 22-bit read pointer and an 8-bit working value. A small decoder understands a few core-instruction payloads:
- One loads a literal into the working value.
- Three copy the working value into the low, high or upper byte of the pointer.

A table-read command fetches one byte from a synchronous memory port at the pointer and advances the pointer by one. The block then drives the fetched byte back onto the shared line during the second half of the same frame's payload.

Top module: `tblrd_responder`

## Requirements
- R1: Each frame is 4 command bits followed by 16 payload bits, each sampled on a falling edge of `pgm_clk`, least significant bit first. Frames follow one another with no gap and no marker.
- R2: Command `4'b0000` marks a core-instruction payload. A payload whose bits [15:8] are `8'h0E` stores bits [7:0] in the working value at the end of the frame.
- R3: A core-instruction payload with bits [15:8] = `8'h6E` and bits [7:0] = `8'hF6`, `8'hF7` or `8'hF8` copies the working value into pointer bits [7:0], [15:8] or [21:16]. For [21:16], only the working value's bits [5:0] are used.
- R4: Command `4'b1001` raises `mem_rd` for one system clock with `mem_addr` equal to the pointer. It then adds one to the pointer. The byte on `mem_rdata` one system clock after `mem_rd` is the byte returned on the link.
- R5: In a read frame, `pgm_oe` rises after the falling edge of the 8th payload clock. `pgm_dout` then shows byte bit 0 and moves to the next higher bit after each later falling edge. Bit k is therefore on the line while payload clock 9+k is high.
- R6: `pgm_oe` falls after the falling edge of the 16th payload clock. It stays low throughout every frame that is not a read.
- R7: Incrementing the pointer from `22'h3FFFFF` gives `22'h000000`.
- R8: Commands other than `0000` and `1001`, and core-instruction payloads other than those in R2 and R3, still use all 20 clocks. They change neither the pointer nor the working value.
- R9: After reset, `pgm_oe` is low, the pointer is 0 and the working value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the link |
| rst_n | input | 1 | Active-low reset |
| pgm_clk | input | 1 | Serial link clock from the host |
| pgm_din | input | 1 | Shared data line as seen by the responder |
| pgm_dout | output | 1 | Data value to drive on the shared line |
| pgm_oe | output | 1 | High while the responder owns the shared line |
| mem_rd | output | 1 | One-cycle byte read request |
| mem_addr | output | 22 | Read address |
| mem_rdata | input | 8 | Read data, valid one cycle after `mem_rd` |

## Verification
The bench sets the pointer bytes from several literals, including alternating-bit and all-ones values. A wrong field position or a skipped upper-byte mask therefore shows up as a different fetched byte.

Back-to-back reads separate a correct increment from a stuck or doubled pointer. A read at the top address tells wrapping apart from overflow into unused bits.

Unknown commands, and unknown instructions carrying decodable-looking operands, come before reads. Any effect they had on state would change the returned data.

The line-ownership window is compared at both phases of every serial clock, so drive that is off by one edge fails.

// File: rtl/tblrd_pkg.sv
package tblrd_pkg;
    localparam int CMD_W  = 4;
    localparam int PAY_W  = 16;
    localparam int BYTE_W = 8;

    localparam logic [CMD_W-1:0]  CMD_CORE  = 4'b0000;
    localparam logic [CMD_W-1:0]  CMD_TBLRD = 4'b1001;

    localparam logic [BYTE_W-1:0] OP_LIT    = 8'h0E;
    localparam logic [BYTE_W-1:0] OP_MOVREG = 8'h6E;
    localparam logic [BYTE_W-1:0] REG_UP    = 8'hF8;
    localparam logic [BYTE_W-1:0] REG_HI    = 8'hF7;
    localparam logic [BYTE_W-1:0] REG_LO    = 8'hF6;
endpackage

// File: rtl/link_sync.sv
module link_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pgm_clk,
    input  logic pgm_din,
    output logic fall,
    output logic din_s
);
    typedef struct packed {
        logic [STAGES-1:0] ck;
        logic [STAGES-1:0] dt;
        logic              ck_prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.ck      = {st_q.ck[STAGES-2:0], pgm_clk};
        st_d.dt      = {st_q.dt[STAGES-2:0], pgm_din};
        st_d.ck_prev = st_q.ck[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fall  = st_q.ck_prev & ~st_q.ck[STAGES-1];
    assign din_s = st_q.dt[STAGES-1];
endmodule

// File: rtl/frame_ctrl.sv
module frame_ctrl
    import tblrd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall,
    input  logic              din,
    input  logic              rd_vld,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic [CMD_W-1:0]  cmd,
    output logic [PAY_W-1:0]  payload,
    output logic              cmd_done,
    output logic              frame_done,
    output logic              dout,
    output logic              oe
);
    localparam int CNT_W = $clog2(CMD_W + PAY_W);
    localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] OE_IDX   = CNT_W'(CMD_W + 7);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CMD_W + PAY_W - 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [CMD_W-1:0]  cmd;
        logic [PAY_W-1:0]  pay;
        logic              cmd_done;
        logic              frame_done;
        logic              is_rd;
        logic              oe;
        logic [BYTE_W-1:0] obyte;
    } frm_t;

    frm_t st_d, st_q;
    logic [CMD_W-1:0] cmd_next;

    always_comb begin
        st_d            = st_q;
        st_d.cmd_done   = 1'b0;
        st_d.frame_done = 1'b0;
        cmd_next        = {din, st_q.cmd[CMD_W-1:1]};
        if (rd_vld) st_d.obyte = rd_byte;
        if (fall) begin
            if (st_q.cnt <= CMD_LAST) st_d.cmd = cmd_next;
            else                      st_d.pay = {din, st_q.pay[PAY_W-1:1]};
            if (st_q.cnt == CMD_LAST) begin
                st_d.cmd_done = 1'b1;
                st_d.is_rd    = (cmd_next == CMD_TBLRD);
            end
            if (st_q.is_rd && st_q.cnt == OE_IDX) st_d.oe = 1'b1;
            if (st_q.oe && st_q.cnt > OE_IDX && st_q.cnt < LAST_IDX)
                st_d.obyte = {1'b0, st_q.obyte[BYTE_W-1:1]};
            if (st_q.cnt == LAST_IDX) begin
                st_d.cnt        = '0;
                st_d.frame_done = 1'b1;
                st_d.oe         = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd        = st_q.cmd;
    assign payload    = st_q.pay;
    assign cmd_done   = st_q.cmd_done;
    assign frame_done = st_q.frame_done;
    assign dout       = st_q.obyte[0];
    assign oe         = st_q.oe;

    assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST_IDX);
    assert_oe_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.oe) |-> st_q.cnt == OE_IDX + 1'b1);
    assert_oe_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.oe |-> (st_q.cnt > OE_IDX && st_q.is_rd));
    assert_oe_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.frame_done |-> !st_q.oe);
endmodule

// File: rtl/ptr_unit.sv
module ptr_unit
    import tblrd_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_done,
    input  logic              frame_done,
    input  logic [CMD_W-1:0]  cmd,
    input  logic [PAY_W-1:0]  payload,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              rd_vld
);
    localparam int UP_W = ADDR_W - 16;

    typedef struct packed {
        logic [BYTE_W-1:0] w;
        logic [ADDR_W-1:0] ptr;
        logic [ADDR_W-1:0] maddr;
        logic              mrd;
        logic              vld;
    } ptr_t;

    ptr_t st_d, st_q;
    logic [BYTE_W-1:0] op_hi, op_lo;

    always_comb begin
        st_d     = st_q;
        st_d.mrd = 1'b0;
        st_d.vld = st_q.mrd;
        op_hi    = payload[PAY_W-1:BYTE_W];
        op_lo    = payload[BYTE_W-1:0];
        if (cmd_done && cmd == CMD_TBLRD) begin
            st_d.mrd   = 1'b1;
            st_d.maddr = st_q.ptr;
            st_d.ptr   = st_q.ptr + 1'b1;
        end
        if (frame_done && cmd == CMD_CORE) begin
            if (op_hi == OP_LIT) begin
                st_d.w = op_lo;
            end else if (op_hi == OP_MOVREG) begin
                case (op_lo)
                    REG_UP:  st_d.ptr[ADDR_W-1:16] = st_q.w[UP_W-1:0];
                    REG_HI:  st_d.ptr[15:8]        = st_q.w;
                    REG_LO:  st_d.ptr[7:0]         = st_q.w;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_rd   = st_q.mrd;
    assign mem_addr = st_q.maddr;
    assign rd_vld   = st_q.vld;

    assert_addr_incr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mrd |-> st_q.ptr == ADDR_W'(st_q.maddr + 1'b1));
    assert_rd_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mrd |=> !st_q.mrd);
    assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mrd && st_q.maddr == '1) |-> st_q.ptr == '0);
    assert_vld_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld |-> $past(st_q.mrd));
endmodule

// File: rtl/tblrd_responder.sv
module tblrd_responder
    import tblrd_pkg::*;
#(
    parameter int ADDR_W      = 22,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pgm_clk,
    input  logic              pgm_din,
    output logic              pgm_dout,
    output logic              pgm_oe,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [BYTE_W-1:0] mem_rdata
);
    logic             fall, din_s, cmd_done, frame_done, rd_vld;
    logic [CMD_W-1:0] cmd;
    logic [PAY_W-1:0] payload;

    link_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pgm_clk (pgm_clk),
        .pgm_din (pgm_din),
        .fall    (fall),
        .din_s   (din_s)
    );

    frame_ctrl u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .fall       (fall),
        .din        (din_s),
        .rd_vld     (rd_vld),
        .rd_byte    (mem_rdata),
        .cmd        (cmd),
        .payload    (payload),
        .cmd_done   (cmd_done),
        .frame_done (frame_done),
        .dout       (pgm_dout),
        .oe         (pgm_oe)
    );

    ptr_unit #(.ADDR_W(ADDR_W)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_done   (cmd_done),
        .frame_done (frame_done),
        .cmd        (cmd),
        .payload    (payload),
        .mem_rd     (mem_rd),
        .mem_addr   (mem_addr),
        .rd_vld     (rd_vld)
    );
endmodule

// File: tb/tblrd_responder_bench.sv
module tblrd_responder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pgm_clk = 1'b0;
    logic        pgm_din = 1'b0;
    logic        pgm_dout, pgm_oe, mem_rd;
    logic [21:0] mem_addr;
    logic [7:0]  mem_rdata = 8'h00;

    int checks = 0;
    int errors = 0;
    int ptr = 0;
    int wv = 0;

    always #10 clk = ~clk;

    tblrd_responder u_tblrd_responder (
        .clk(clk), .rst_n(rst_n), .pgm_clk(pgm_clk), .pgm_din(pgm_din),
        .pgm_dout(pgm_dout), .pgm_oe(pgm_oe), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] mem_f(input logic [21:0] a);
        return a[7:0] ^ a[15:8] ^ {a[21:16], 2'b11} ^ 8'h5A;
    endfunction

    always_ff @(posedge clk) if (mem_rd) mem_rdata <= mem_f(mem_addr);

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic frame(input string tag, input logic [3:0] cmd, input logic [15:0] pay);
        bit rd = (cmd == 4'b1001);
        logic [7:0] eb = mem_f(22'(ptr));
        for (int i = 0; i < 20; i++) begin
            pgm_din = (i < 4) ? cmd[i] : (rd ? 1'b0 : pay[i-4]);
            pgm_clk = 1'b1;
            repeat (8) @(posedge clk);
            #2;
            if (rd && i >= 12) begin
                check({tag, " R5 oe high phase"}, int'(pgm_oe), 1);
                check({tag, " R4 data bit"}, int'(pgm_dout), int'(eb[i-12]));
            end else begin
                check({tag, " R6 oe idle high phase"}, int'(pgm_oe), 0);
            end
            pgm_clk = 1'b0;
            repeat (8) @(posedge clk);
            #2;
            if (rd && i >= 11 && i <= 18) begin
                check({tag, " R5 oe low phase"}, int'(pgm_oe), 1);
                check({tag, " R5 data bit"}, int'(pgm_dout), int'(eb[i-11]));
            end else begin
                check({tag, " R6 oe idle low phase"}, int'(pgm_oe), 0);
            end
        end
        if (rd) ptr = (ptr + 1) & 32'h3FFFFF;
        if (cmd == 4'b0000) begin
            if (pay[15:8] == 8'h0E) wv = int'(pay[7:0]);
            else if (pay[15:8] == 8'h6E) begin
                case (pay[7:0])
                    8'hF8: ptr = (ptr & 32'h00FFFF) | ((wv & 32'h3F) << 16);
                    8'hF7: ptr = (ptr & 32'h3F00FF) | (wv << 8);
                    8'hF6: ptr = (ptr & 32'h3FFF00) | wv;
                    default: ;
                endcase
            end
        end
    endtask

    task automatic set_ptr(input string tag, input logic [7:0] up, input logic [7:0] hi, input logic [7:0] lo);
        frame(tag, 4'b0000, {8'h0E, up}); frame(tag, 4'b0000, 16'h6EF8);
        frame(tag, 4'b0000, {8'h0E, hi}); frame(tag, 4'b0000, 16'h6EF7);
        frame(tag, 4'b0000, {8'h0E, lo}); frame(tag, 4'b0000, 16'h6EF6);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #2;
        check("R9 oe after reset", int'(pgm_oe), 0);
        rst_n = 1'b1;
        repeat (4) @(posedge clk);
        frame("R9 read at zero pointer", 4'b1001, 16'h0000);
        set_ptr("R2 R3 pointer load", 8'h12, 8'h34, 8'h56);
        frame("R1 read", 4'b1001, 16'h0000);
        frame("R4 next read", 4'b1001, 16'h0000);
        set_ptr("R1 alternating bits", 8'hAA, 8'h55, 8'hA5);
        frame("R1 read alt", 4'b1001, 16'h0000);
        set_ptr("R3 upper mask", 8'hFF, 8'hFF, 8'hFE);
        frame("R4 read top-1", 4'b1001, 16'h0000);
        frame("R4 read top", 4'b1001, 16'h0000);
        frame("R7 read after wrap", 4'b1001, 16'h0000);
        frame("R2 lit", 4'b0000, 16'h0E3C);
        frame("R8 unknown cmd", 4'b1101, 16'h6EF6);
        frame("R8 unknown cmd lit", 4'b0001, 16'h0E77);
        frame("R8 unknown reg", 4'b0000, 16'h6EF5);
        frame("R8 unknown op", 4'b0000, 16'h0FAA);
        frame("R8 read unchanged", 4'b1001, 16'h0000);
        frame("R3 low copy", 4'b0000, 16'h6EF6);
        frame("R8 read after copy", 4'b1001, 16'h0000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule